// File: doc/BRIEF.md
# Dual-Algorithm Message Digest Engine

This block hashes a message with either SHA-1 or MD5 using one shared, iterative datapath. The host or a DMA channel delivers the message as 512-bit blocks, one 32-bit word per handshake, sixteen words per block. Message padding and the length field are already in the data the host sends. The engine keeps the chaining state from one block to the next, so a message of any number of blocks is hashed by sending its blocks back to back. The first block of a message is marked so that the chaining state starts from the algorithm's initial values.

Once the sixteenth word of a block has been accepted, the engine runs one compression step per clock. A SHA-1 block takes 80 steps and an MD5 block takes 64. While the steps run, the block reports busy and refuses further words. When the last step is done, the working variables are added into the chaining state. The digest port then shows the running digest of every block so far: 160 bits for SHA-1, or 128 bits for MD5 placed in the upper part of the port.

Top module: `dual_hash_core`

## Requirements
- R1: With alg_sel=0 (SHA-1), a single padded block gives the 160-bit SHA-1 digest on `digest`. The first digest byte is in bits [159:152].
- R2: With alg_sel=1 (MD5), a single padded block gives the 128-bit MD5 digest in `digest[159:32]`, first digest byte in bits [159:152], and `digest[31:0]` reads zero.
- R3: In SHA-1, a second block sent with first_blk=0 is compressed starting from the chaining state that the first block left.
- R4: In MD5, a second block sent with first_blk=0 is compressed starting from the chaining state that the first block left.
- R5: In SHA-1, `busy` goes high at the clock edge that accepts the 16th word of a block and stays high for exactly 80 cycles.
- R6: In MD5, `busy` stays high for exactly 64 cycles after the 16th word is accepted.
- R7: While `busy` is high, `in_ready` is low, and words offered on `in_valid` are neither taken nor allowed to disturb the result.
- R8: `in_word[31:24]` carries the earliest message byte of the word. SHA-1 uses the word as a big-endian value. MD5 byte-swaps it into a little-endian value.
- R9: `first_blk` is sampled with word 0 of a block. When it is 1, the chaining state is reloaded with the initial values, so a new message is hashed correctly after any earlier message.
- R10: `alg_sel` is sampled only with word 0 of a first block. Its value on later blocks of the same message has no effect.
- R11: After reset, `busy`=0, `in_ready`=1 and `digest_valid`=0.
- R12: `digest_valid` rises when the last step of a block completes. It falls when word 0 of the next block is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| alg_sel | input | 1 | 0 = SHA-1, 1 = MD5, sampled with word 0 of a first block |
| first_blk | input | 1 | 1 marks the block that starts a message, sampled with word 0 |
| in_valid | input | 1 | A message word is offered |
| in_ready | output | 1 | The engine accepts a word at this edge |
| in_word | input | 32 | Message word, earliest byte in [31:24] |
| busy | output | 1 | Compression steps are running |
| digest_valid | output | 1 | `digest` holds the result of the last finished block |
| digest | output | 160 | Digest, first byte in [159:152]; MD5 uses [159:32] |

## Verification
The bench uses the short message "abc" and the empty message in both algorithms. A wrong round function, constant table or byte swap changes the one-block digest, and the empty message also shows that the padding word is handled with the right byte order. Two-block messages test chaining: the 56-byte alphabet string for SHA-1 and the 80-digit string for MD5. The SHA-1 message flips `alg_sel` on its second block. The MD5 message offers junk words while the engine is busy. Repeating "abc" after other messages separates a true reload of the initial values from leftover chaining state. The busy window is counted per algorithm, which separates the 80-step limit from the 64-step limit.

// File: rtl/hm_pkg.sv
package hm_pkg;
    localparam int WW      = 32;
    localparam int NWORDS  = 16;
    localparam int IDX_W   = $clog2(NWORDS);
    localparam int SHA_N   = 80;
    localparam int MD5_N   = 64;
    localparam int STEP_W  = $clog2(SHA_N);
    localparam int DIG_W   = 5 * WW;

    typedef logic [WW-1:0] word_t;

    typedef enum logic {ALG_SHA1 = 1'b0, ALG_MD5 = 1'b1} alg_e;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } wvars_t;

    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
        logic [IDX_W-1:0]  widx;
        alg_e              alg;
        logic              dvalid;
        wvars_t            wv;
        wvars_t            hv;
    } ctl_t;

    function automatic word_t rotl(word_t x, int n);
        return (x << n) | (x >> (WW - n));
    endfunction

    function automatic word_t bswap(word_t x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic wvars_t init_vals();
        wvars_t v;
        v.a = 32'h67452301;
        v.b = 32'hefcdab89;
        v.c = 32'h98badcfe;
        v.d = 32'h10325476;
        v.e = 32'hc3d2e1f0;
        return v;
    endfunction

    function automatic logic [4:0] md5_rot(logic [5:0] t);
        logic [4:0] r;
        case ({t[5:4], t[1:0]})
            4'h0: r = 5'd7;   4'h1: r = 5'd12; 4'h2: r = 5'd17; 4'h3: r = 5'd22;
            4'h4: r = 5'd5;   4'h5: r = 5'd9;  4'h6: r = 5'd14; 4'h7: r = 5'd20;
            4'h8: r = 5'd4;   4'h9: r = 5'd11; 4'ha: r = 5'd16; 4'hb: r = 5'd23;
            4'hc: r = 5'd6;   4'hd: r = 5'd10; 4'he: r = 5'd15; default: r = 5'd21;
        endcase
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] md5_widx(logic [5:0] t);
        logic [IDX_W-1:0] x;
        logic [IDX_W-1:0] g;
        x = t[3:0];
        case (t[5:4])
            2'd0:    g = x;
            2'd1:    g = x * 4'd5 + 4'd1;
            2'd2:    g = x * 4'd3 + 4'd5;
            default: g = x * 4'd7;
        endcase
        return g;
    endfunction

    function automatic word_t md5_const(logic [5:0] t);
        word_t k;
        case (t)
            6'd0:  k = 32'hd76aa478; 6'd1:  k = 32'he8c7b756; 6'd2:  k = 32'h242070db; 6'd3:  k = 32'hc1bdceee;
            6'd4:  k = 32'hf57c0faf; 6'd5:  k = 32'h4787c62a; 6'd6:  k = 32'ha8304613; 6'd7:  k = 32'hfd469501;
            6'd8:  k = 32'h698098d8; 6'd9:  k = 32'h8b44f7af; 6'd10: k = 32'hffff5bb1; 6'd11: k = 32'h895cd7be;
            6'd12: k = 32'h6b901122; 6'd13: k = 32'hfd987193; 6'd14: k = 32'ha679438e; 6'd15: k = 32'h49b40821;
            6'd16: k = 32'hf61e2562; 6'd17: k = 32'hc040b340; 6'd18: k = 32'h265e5a51; 6'd19: k = 32'he9b6c7aa;
            6'd20: k = 32'hd62f105d; 6'd21: k = 32'h02441453; 6'd22: k = 32'hd8a1e681; 6'd23: k = 32'he7d3fbc8;
            6'd24: k = 32'h21e1cde6; 6'd25: k = 32'hc33707d6; 6'd26: k = 32'hf4d50d87; 6'd27: k = 32'h455a14ed;
            6'd28: k = 32'ha9e3e905; 6'd29: k = 32'hfcefa3f8; 6'd30: k = 32'h676f02d9; 6'd31: k = 32'h8d2a4c8a;
            6'd32: k = 32'hfffa3942; 6'd33: k = 32'h8771f681; 6'd34: k = 32'h6d9d6122; 6'd35: k = 32'hfde5380c;
            6'd36: k = 32'ha4beea44; 6'd37: k = 32'h4bdecfa9; 6'd38: k = 32'hf6bb4b60; 6'd39: k = 32'hbebfbc70;
            6'd40: k = 32'h289b7ec6; 6'd41: k = 32'heaa127fa; 6'd42: k = 32'hd4ef3085; 6'd43: k = 32'h04881d05;
            6'd44: k = 32'hd9d4d039; 6'd45: k = 32'he6db99e5; 6'd46: k = 32'h1fa27cf8; 6'd47: k = 32'hc4ac5665;
            6'd48: k = 32'hf4292244; 6'd49: k = 32'h432aff97; 6'd50: k = 32'hab9423a7; 6'd51: k = 32'hfc93a039;
            6'd52: k = 32'h655b59c3; 6'd53: k = 32'h8f0ccc92; 6'd54: k = 32'hffeff47d; 6'd55: k = 32'h85845dd1;
            6'd56: k = 32'h6fa87e4f; 6'd57: k = 32'hfe2ce6e0; 6'd58: k = 32'ha3014314; 6'd59: k = 32'h4e0811a1;
            6'd60: k = 32'hf7537e82; 6'd61: k = 32'hbd3af235; 6'd62: k = 32'h2ad7d2bb; default: k = 32'heb86d391;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/hm_msg_sched.sv
module hm_msg_sched
    import hm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  word_t             load_word,
    input  logic              step_en,
    input  alg_e              alg,
    input  logic [STEP_W-1:0] step,
    output word_t             w_t
);
    logic [NWORDS-1:0][WW-1:0] mem_d, mem_q;
    logic [IDX_W-1:0]          slot;
    word_t                     expand;

    always_comb begin
        slot   = step[IDX_W-1:0];
        expand = rotl(mem_q[slot - 4'd3] ^ mem_q[slot - 4'd8] ^
                      mem_q[slot - 4'd14] ^ mem_q[slot], 1);
        if (alg == ALG_MD5)
            w_t = mem_q[md5_widx(step[5:0])];
        else if (step < STEP_W'(NWORDS))
            w_t = mem_q[slot];
        else
            w_t = expand;

        mem_d = mem_q;
        if (load_en)
            mem_d[load_idx] = load_word;
        else if (step_en && alg == ALG_SHA1 && step >= STEP_W'(NWORDS))
            mem_d[slot] = expand;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // MD5 reads its block words in permuted order and never rewrites them
    p_md5_buf_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && alg == ALG_MD5 && !load_en) |=> $stable(mem_q));
endmodule

// File: rtl/hm_step.sv
module hm_step
    import hm_pkg::*;
(
    input  alg_e              alg,
    input  logic [STEP_W-1:0] step,
    input  wvars_t            cur,
    input  word_t             w,
    output wvars_t            nxt
);
    word_t f, k, tmp;

    always_comb begin
        nxt = cur;
        f   = '0;
        k   = '0;
        tmp = '0;
        if (alg == ALG_SHA1) begin
            if (step < 7'd20) begin
                f = (cur.b & cur.c) | (~cur.b & cur.d);
                k = 32'h5a827999;
            end else if (step < 7'd40) begin
                f = cur.b ^ cur.c ^ cur.d;
                k = 32'h6ed9eba1;
            end else if (step < 7'd60) begin
                f = (cur.b & cur.c) | (cur.b & cur.d) | (cur.c & cur.d);
                k = 32'h8f1bbcdc;
            end else begin
                f = cur.b ^ cur.c ^ cur.d;
                k = 32'hca62c1d6;
            end
            tmp   = rotl(cur.a, 5) + f + cur.e + k + w;
            nxt.e = cur.d;
            nxt.d = cur.c;
            nxt.c = rotl(cur.b, 30);
            nxt.b = cur.a;
            nxt.a = tmp;
        end else begin
            case (step[5:4])
                2'd0:    f = (cur.b & cur.c) | (~cur.b & cur.d);
                2'd1:    f = (cur.d & cur.b) | (~cur.d & cur.c);
                2'd2:    f = cur.b ^ cur.c ^ cur.d;
                default: f = cur.c ^ (cur.b | ~cur.d);
            endcase
            k     = md5_const(step[5:0]);
            tmp   = cur.a + f + k + w;
            nxt.a = cur.d;
            nxt.d = cur.c;
            nxt.c = cur.b;
            nxt.b = cur.b + rotl(tmp, int'(md5_rot(step[5:0])));
        end
    end
endmodule

// File: rtl/dual_hash_core.sv
module dual_hash_core
    import hm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alg_sel,
    input  logic             first_blk,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WW-1:0]    in_word,
    output logic             busy,
    output logic             digest_valid,
    output logic [DIG_W-1:0] digest
);
    ctl_t              ctl_d, ctl_q;
    wvars_t            step_nxt;
    word_t             w_t, load_word;
    logic              load_fire;
    alg_e              eff_alg;
    logic [STEP_W-1:0] last_step;

    hm_msg_sched u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_fire),
        .load_idx  (ctl_q.widx),
        .load_word (load_word),
        .step_en   (ctl_q.run),
        .alg       (ctl_q.alg),
        .step      (ctl_q.step),
        .w_t       (w_t)
    );

    hm_step u_step (
        .alg  (ctl_q.alg),
        .step (ctl_q.step),
        .cur  (ctl_q.wv),
        .w    (w_t),
        .nxt  (step_nxt)
    );

    always_comb begin
        ctl_d     = ctl_q;
        load_fire = !ctl_q.run && in_valid;
        eff_alg   = (load_fire && ctl_q.widx == '0 && first_blk) ? alg_e'(alg_sel) : ctl_q.alg;
        load_word = (eff_alg == ALG_MD5) ? bswap(in_word) : in_word;
        last_step = (ctl_q.alg == ALG_MD5) ? STEP_W'(MD5_N - 1) : STEP_W'(SHA_N - 1);

        if (load_fire) begin
            ctl_d.widx = ctl_q.widx + 1'b1;
            if (ctl_q.widx == '0) begin
                ctl_d.dvalid = 1'b0;
                if (first_blk) begin
                    ctl_d.alg = alg_e'(alg_sel);
                    ctl_d.hv  = init_vals();
                end
            end
            if (ctl_q.widx == IDX_W'(NWORDS - 1)) begin
                ctl_d.run  = 1'b1;
                ctl_d.step = '0;
                ctl_d.wv   = ctl_q.hv;
            end
        end

        if (ctl_q.run) begin
            ctl_d.wv   = step_nxt;
            ctl_d.step = ctl_q.step + 1'b1;
            if (ctl_q.step == last_step) begin
                ctl_d.run    = 1'b0;
                ctl_d.step   = '0;
                ctl_d.dvalid = 1'b1;
                ctl_d.hv.a   = ctl_q.hv.a + step_nxt.a;
                ctl_d.hv.b   = ctl_q.hv.b + step_nxt.b;
                ctl_d.hv.c   = ctl_q.hv.c + step_nxt.c;
                ctl_d.hv.d   = ctl_q.hv.d + step_nxt.d;
                if (ctl_q.alg == ALG_SHA1)
                    ctl_d.hv.e = ctl_q.hv.e + step_nxt.e;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.alg  <= ALG_SHA1;
            ctl_q.hv   <= init_vals();
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready     = !ctl_q.run;
    assign busy         = ctl_q.run;
    assign digest_valid = ctl_q.dvalid;
    assign digest       = (ctl_q.alg == ALG_MD5)
                        ? {bswap(ctl_q.hv.a), bswap(ctl_q.hv.b), bswap(ctl_q.hv.c),
                           bswap(ctl_q.hv.d), {WW{1'b0}}}
                        : {ctl_q.hv.a, ctl_q.hv.b, ctl_q.hv.c, ctl_q.hv.d, ctl_q.hv.e};

    // step counter never passes the algorithm's last step
    p_step_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctl_q.step <= ((ctl_q.alg == ALG_MD5) ? STEP_W'(MD5_N - 1) : STEP_W'(SHA_N - 1))));

    // busy ends only after the final step of the running algorithm
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(ctl_q.step) == (($past(ctl_q.alg) == ALG_MD5)
                          ? STEP_W'(MD5_N - 1) : STEP_W'(SHA_N - 1))));

    // compression starts only from a full block accepted at the port
    p_start_after_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(in_valid) && $past(ctl_q.widx) == IDX_W'(NWORDS - 1)));

    // algorithm latch changes only with word 0 of a block
    p_alg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.widx != '0 || busy) |=> $stable(ctl_q.alg));

    // a fresh digest appears exactly when a block finishes
    p_dvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(digest_valid) |-> $fell(busy));
endmodule

// File: tb/dual_hash_core_bench.sv
module dual_hash_core_bench;
    typedef logic [0:15][31:0] blk_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         alg_sel = 1'b0;
    logic         first_blk = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_word = '0;
    logic         busy;
    logic         digest_valid;
    logic [159:0] digest;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    dual_hash_core u_dual_hash_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .alg_sel      (alg_sel),
        .first_blk    (first_blk),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_word      (in_word),
        .busy         (busy),
        .digest_valid (digest_valid),
        .digest       (digest)
    );

    task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h exp %h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [31:0] w);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // sends one block; alg_w0 goes with word 0, alg_rest with words 1..15
    task automatic send_block(input blk_t b, input logic alg_w0, input logic alg_rest, input logic first);
        for (int i = 0; i < 16; i++) begin
            alg_sel   = (i == 0) ? alg_w0 : alg_rest;
            first_blk = (i == 0) ? first : 1'b0;
            put_word(b[i]);
            if (i == 0) chk(digest_valid == 1'b0, "R12 dvalid clears on word0", {159'd0, digest_valid}, 160'd0);
        end
        first_blk = 1'b0;
    endtask

    // counts busy cycles; optionally offers junk words while busy
    task automatic wait_done(input bit junk, output int cnt);
        cnt = 0;
        while (busy && cnt < 1000) begin
            if (junk && cnt < 10) begin
                in_valid = 1'b1;
                in_word  = 32'hdeadbeef;
                chk(in_ready == 1'b0, "R7 ready low while busy", {159'd0, in_ready}, 160'd0);
            end else begin
                in_valid = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(digest_valid == 1'b1, "R12 dvalid after block", {159'd0, digest_valid}, 160'd1);
    endtask

    function automatic blk_t abc_sha();
        blk_t b = '0;
        b[0] = 32'h61626380; b[15] = 32'h00000018;
        return b;
    endfunction

    function automatic blk_t abc_md5();
        blk_t b = '0;
        b[0] = 32'h61626380; b[14] = 32'h18000000;
        return b;
    endfunction

    task automatic t_reset();
        chk(busy == 1'b0, "R11 busy", {159'd0, busy}, 160'd0);
        chk(in_ready == 1'b1, "R11 in_ready", {159'd0, in_ready}, 160'd1);
        chk(digest_valid == 1'b0, "R11 digest_valid", {159'd0, digest_valid}, 160'd0);
    endtask

    task automatic t_sha_abc(input string tag);
        int n;
        send_block(abc_sha(), 1'b0, 1'b0, 1'b1);
        wait_done(1'b0, n);
        chk(n == 80, "R5 sha busy cycles", 160'(n), 160'd80);
        chk(digest == 160'ha9993e364706816aba3e25717850c26c9cd0d89d, tag, digest,
            160'ha9993e364706816aba3e25717850c26c9cd0d89d);
    endtask

    task automatic t_md5_abc();
        int n;
        send_block(abc_md5(), 1'b1, 1'b1, 1'b1);
        wait_done(1'b0, n);
        chk(n == 64, "R6 md5 busy cycles", 160'(n), 160'd64);
        chk(digest == {128'h900150983cd24fb0d6963f7d28e17f72, 32'h0}, "R2 R8 md5 abc", digest,
            {128'h900150983cd24fb0d6963f7d28e17f72, 32'h0});
    endtask

    task automatic t_empty();
        int   n;
        blk_t b = '0;
        b[0] = 32'h80000000;
        send_block(b, 1'b0, 1'b0, 1'b1);
        wait_done(1'b0, n);
        chk(digest == 160'hda39a3ee5e6b4b0d3255bfef95601890afd80709, "R1 R9 sha empty", digest,
            160'hda39a3ee5e6b4b0d3255bfef95601890afd80709);
        send_block(b, 1'b1, 1'b1, 1'b1);
        wait_done(1'b0, n);
        chk(digest == {128'hd41d8cd98f00b204e9800998ecf8427e, 32'h0}, "R2 R8 md5 empty", digest,
            {128'hd41d8cd98f00b204e9800998ecf8427e, 32'h0});
    endtask

    task automatic t_sha_two();
        int   n;
        blk_t b1 = '0;
        blk_t b2 = '0;
        b1[0] = "abcd"; b1[1] = "bcde"; b1[2] = "cdef"; b1[3] = "defg"; b1[4] = "efgh";
        b1[5] = "fghi"; b1[6] = "ghij"; b1[7] = "hijk"; b1[8] = "ijkl"; b1[9] = "jklm";
        b1[10] = "klmn"; b1[11] = "lmno"; b1[12] = "mnop"; b1[13] = "nopq"; b1[14] = 32'h80000000;
        b2[15] = 32'h000001c0;
        send_block(b1, 1'b0, 1'b0, 1'b1);
        wait_done(1'b0, n);
        // R10: alg_sel held at MD5 for the whole second block
        send_block(b2, 1'b1, 1'b1, 1'b0);
        wait_done(1'b0, n);
        chk(n == 80, "R10 still sha step count", 160'(n), 160'd80);
        chk(digest == 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1, "R3 R10 sha two-block", digest,
            160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1);
    endtask

    task automatic t_md5_two();
        int   n;
        blk_t b1;
        blk_t b2 = '0;
        logic [4:0][31:0] pat;
        pat = {"1234", "5678", "9012", "3456", "7890"};
        for (int i = 0; i < 16; i++) b1[i] = pat[4 - (i % 5)];
        b2[0] = "5678"; b2[1] = "9012"; b2[2] = "3456"; b2[3] = "7890";
        b2[4] = 32'h80000000; b2[14] = 32'h80020000;
        send_block(b1, 1'b1, 1'b1, 1'b1);
        wait_done(1'b1, n);
        chk(n == 64, "R6 R7 busy with junk offered", 160'(n), 160'd64);
        send_block(b2, 1'b0, 1'b0, 1'b0);
        wait_done(1'b1, n);
        chk(digest == {128'h57edf4a22be3c955ac49da2e2107b67a, 32'h0}, "R4 R7 md5 two-block", digest,
            {128'h57edf4a22be3c955ac49da2e2107b67a, 32'h0});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sha_abc("R1 R8 sha abc");
        t_md5_abc();
        t_empty();
        t_sha_two();
        t_md5_two();
        t_sha_abc("R9 sha abc after other messages");
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule